// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block keeps the status word of each channel of a multi-channel DMA controller. The transfer engine raises per-channel event pulses: start, end, stop, request-after-stop and end-of-receive. Each pulse sets a sticky flag in that channel's word. Software clears a flag by writing a one to it. The rest of the word holds the channel's control and enable bits, which are stored exactly as written.

From the stored words the block builds five event vectors, each one bit per channel. Stop, end-of-receive and request-after-stop only show in their vector when the channel's matching enable bit is also set. Start and end show unconditionally. A single interrupt line is the registered OR of all five vectors.

A combinational read port returns any channel's word. The channel's live request input is merged in as the request-pending bit, which is never stored. Channel words sit at consecutive 4-byte offsets from address 0.

Top module: `dmairq_top`

## Requirements
- R1: While reset is held and after it is released, every channel word reads 0, all five vectors are 0 and `irq` is 0.
- R2: `stopVec[c]` is 1 exactly when channel c has both stop-enable (bit 29) and stop status (bit 3) set.
- R3: `eorVec[c]` is 1 exactly when channel c has both end-of-receive enable (bit 28) and end-of-receive status (bit 9) set.
- R4: `rasVec[c]` is 1 exactly when channel c has both request-after-stop enable (bit 23) and request-after-stop status (bit 4) set.
- R5: `startVec[c]` follows start status (bit 1) and `endVec[c]` follows end status (bit 2), with no enable bit involved.
- R6: `irq` is registered. It goes to 1 one clock after any vector bit becomes 1, and to 0 one clock after all vector bits are 0.
- R7: `rdData` returns the addressed channel's stored word with bit 8 (request pending) ORed in from that channel's `reqIn`, combinationally and in the same cycle.
- R8: A write with a 1 in any status bit (bits 1, 2, 3, 4, 9) clears that bit. A 0 there leaves the bit unchanged. Bit 0 always reads 0.
- R9: An event pulse for a bit wins over a clearing write to the same bit of the same channel in the same cycle.
- R10: All bits other than 0, 1, 2, 3, 4, 8 and 9 are control bits. A write stores them exactly as given.
- R11: Channel c is addressed at byte offset 4*c. Address bits [1:0] are ignored, and a write changes no other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one channel word |
| wrAddr | input | $clog2(NUM_CH)+2 | Byte address of the written word |
| wrData | input | 32 | Write data (control bits stored, status bits clear on 1) |
| rdAddr | input | $clog2(NUM_CH)+2 | Byte address of the read word |
| rdData | output | 32 | Addressed word with live request-pending bit |
| reqIn | input | NUM_CH | Per-channel live request |
| setStart | input | NUM_CH | Per-channel start event pulse |
| setEnd | input | NUM_CH | Per-channel end event pulse |
| setStop | input | NUM_CH | Per-channel stop event pulse |
| setRas | input | NUM_CH | Per-channel request-after-stop event pulse |
| setEor | input | NUM_CH | Per-channel end-of-receive event pulse |
| stopVec | output | NUM_CH | Enabled stop events |
| eorVec | output | NUM_CH | Enabled end-of-receive events |
| rasVec | output | NUM_CH | Enabled request-after-stop events |
| startVec | output | NUM_CH | Start events |
| endVec | output | NUM_CH | End events |
| irq | output | 1 | Registered OR of all vectors |

## Verification
A corrupted status flag shows up combinationally on both `rdData` and the matching vector in the cycle after the event or write edge. The `irq` line follows it one cycle later. A write decoded to the wrong channel shows when the untouched neighbour channel is read back. A wrong set-versus-clear priority leaves a flag at 0 right after a cycle where both happen.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

  localparam int WORD_W   = 32;
  localparam int IDX_W    = 5;   // covers up to 32 channels

  localparam int BIT_BUSERR = 0;
  localparam int BIT_START  = 1;
  localparam int BIT_END    = 2;
  localparam int BIT_STOP   = 3;
  localparam int BIT_RAS    = 4;
  localparam int BIT_REQ    = 8;
  localparam int BIT_EOR    = 9;
  localparam int BIT_RASEN  = 23;
  localparam int BIT_EOREN  = 28;
  localparam int BIT_STOPEN = 29;

  localparam logic [WORD_W-1:0] CLR_MASK =
    (WORD_W'(1) << BIT_START) | (WORD_W'(1) << BIT_END) |
    (WORD_W'(1) << BIT_STOP)  | (WORD_W'(1) << BIT_RAS) |
    (WORD_W'(1) << BIT_EOR);

  localparam logic [WORD_W-1:0] CTRL_MASK =
    ~(CLR_MASK | (WORD_W'(1) << BIT_REQ) | (WORD_W'(1) << BIT_BUSERR));

  typedef struct packed {
    logic              wrHit;
    logic [IDX_W-1:0]  wrIdx;
    logic [WORD_W-1:0] ctrlData;
    logic [WORD_W-1:0] clrBits;
  } dmairq_strobe_t;

endpackage

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = $clog2(NUM_CH) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              anyPending,
  output dmairq_strobe_t    strb,
  output logic              irq
);

  localparam int CH_W = ADDR_W - 2;

  // Write decode: split data into stored control bits and clear requests.
  always_comb begin
    strb          = '0;
    strb.wrHit    = wrEn;
    strb.wrIdx    = IDX_W'(wrAddr[ADDR_W-1:2]);
    strb.ctrlData = wrData & CTRL_MASK;
    strb.clrBits  = wrData & CLR_MASK;
  end

  // Registered interrupt line (R6).
  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= anyPending;
  end

  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    anyPending |=> irq);
  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    !anyPending |=> !irq);

  initial begin
    if (CH_W > IDX_W) $error("NUM_CH exceeds supported channel count");
  end

endmodule

// File: rtl/dmairq_datapath.sv
module dmairq_datapath
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmairq_strobe_t    strb,
  input  logic [NUM_CH-1:0] reqIn,
  input  logic [NUM_CH-1:0] setStart,
  input  logic [NUM_CH-1:0] setEnd,
  input  logic [NUM_CH-1:0] setStop,
  input  logic [NUM_CH-1:0] setRas,
  input  logic [NUM_CH-1:0] setEor,
  input  logic [CH_W-1:0]   rdIdx,
  output logic [WORD_W-1:0] rdData,
  output logic [NUM_CH-1:0] stopVec,
  output logic [NUM_CH-1:0] eorVec,
  output logic [NUM_CH-1:0] rasVec,
  output logic [NUM_CH-1:0] startVec,
  output logic [NUM_CH-1:0] endVec,
  output logic              anyPending
);

  logic [WORD_W-1:0] statusQ  [NUM_CH];
  logic [WORD_W-1:0] statusD  [NUM_CH];
  logic [WORD_W-1:0] setWord  [NUM_CH];
  logic [WORD_W-1:0] clrEff   [NUM_CH];
  logic [NUM_CH-1:0] chanHit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign chanHit[c] = strb.wrHit && (strb.wrIdx == IDX_W'(c));

    always_comb begin
      setWord[c] = '0;
      setWord[c][BIT_START] = setStart[c];
      setWord[c][BIT_END]   = setEnd[c];
      setWord[c][BIT_STOP]  = setStop[c];
      setWord[c][BIT_RAS]   = setRas[c];
      setWord[c][BIT_EOR]   = setEor[c];
    end

    assign clrEff[c] = chanHit[c] ? (strb.clrBits & ~setWord[c]) : '0;

    always_comb begin
      statusD[c] = statusQ[c];
      if (chanHit[c])
        statusD[c] = (statusQ[c] & CLR_MASK & ~strb.clrBits) | strb.ctrlData;
      statusD[c] = statusD[c] | setWord[c];   // event wins (R9)
    end

    always_ff @(posedge clk) begin
      if (!rstN) statusQ[c] <= '0;
      else       statusQ[c] <= statusD[c];
    end

    // Enabled event vectors (R2..R5).
    assign stopVec[c]  = statusQ[c][BIT_STOPEN] & statusQ[c][BIT_STOP];
    assign eorVec[c]   = statusQ[c][BIT_EOREN]  & statusQ[c][BIT_EOR];
    assign rasVec[c]   = statusQ[c][BIT_RASEN]  & statusQ[c][BIT_RAS];
    assign startVec[c] = statusQ[c][BIT_START];
    assign endVec[c]   = statusQ[c][BIT_END];

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
      (setWord[c] != '0) |=> ((statusQ[c] & $past(setWord[c])) == $past(setWord[c])));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
      (clrEff[c] != '0) |=> ((statusQ[c] & $past(clrEff[c])) == '0));
  end

  assign anyPending = |{stopVec, eorVec, rasVec, startVec, endVec};

  // Read with live request-pending merge (R7).
  always_comb begin
    rdData = statusQ[rdIdx];
    rdData[BIT_REQ] = reqIn[rdIdx];
  end

endmodule

// File: rtl/dmairq_top.sv
module dmairq_top
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  input  logic [NUM_CH-1:0] reqIn,
  input  logic [NUM_CH-1:0] setStart,
  input  logic [NUM_CH-1:0] setEnd,
  input  logic [NUM_CH-1:0] setStop,
  input  logic [NUM_CH-1:0] setRas,
  input  logic [NUM_CH-1:0] setEor,
  output logic [NUM_CH-1:0] stopVec,
  output logic [NUM_CH-1:0] eorVec,
  output logic [NUM_CH-1:0] rasVec,
  output logic [NUM_CH-1:0] startVec,
  output logic [NUM_CH-1:0] endVec,
  output logic              irq
);

  dmairq_strobe_t strb;
  logic           anyPending;

  dmairq_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .anyPending(anyPending), .strb(strb), .irq(irq)
  );

  dmairq_datapath #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqIn(reqIn),
    .setStart(setStart), .setEnd(setEnd), .setStop(setStop),
    .setRas(setRas), .setEor(setEor), .rdIdx(rdAddr[ADDR_W-1:2]),
    .rdData(rdData), .stopVec(stopVec), .eorVec(eorVec), .rasVec(rasVec),
    .startVec(startVec), .endVec(endVec), .anyPending(anyPending)
  );

endmodule

// File: tb/sim_dmairq_top.sv
module sim_dmairq_top;

  localparam int PERIOD = 10;
  localparam int NCH    = 16;
  localparam int AW     = $clog2(NCH) + 2;
  localparam logic [31:0] CLR_ALL = 32'h0000_021F;

  typedef struct packed {
    logic [7:0]  chan;
    logic [31:0] ctrl;
    logic [4:0]  sets;     // {eor, ras, stop, end, start}
    logic        req;
    logic [4:0]  expVec;   // {stop, eor, ras, start, end}
    logic [31:0] expRead;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t TABLE [NVEC] = '{
    '{8'd0,  32'h0000_0000, 5'b00100, 1'b0, 5'b00000, 32'h0000_0008},
    '{8'd1,  32'h2000_0000, 5'b00100, 1'b0, 5'b10000, 32'h2000_0008},
    '{8'd2,  32'h1000_0000, 5'b10000, 1'b1, 5'b01000, 32'h1000_0300},
    '{8'd3,  32'h0080_0000, 5'b01000, 1'b0, 5'b00100, 32'h0080_0010},
    '{8'd5,  32'h0000_0000, 5'b00001, 1'b0, 5'b00010, 32'h0000_0002},
    '{8'd7,  32'h0000_0000, 5'b00010, 1'b0, 5'b00001, 32'h0000_0004},
    '{8'd15, 32'h3080_0000, 5'b11111, 1'b1, 5'b11111, 32'h3080_031E},
    '{8'd9,  32'h1000_0000, 5'b01100, 1'b0, 5'b00000, 32'h1000_0018},
    '{8'd4,  32'h4000_0400, 5'b00000, 1'b0, 5'b00000, 32'h4000_0400}
  };

  logic clk = 1'b0;
  logic rstN;
  logic wrEn;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [31:0] wrData, rdData;
  logic [NCH-1:0] reqIn, setStart, setEnd, setStop, setRas, setEor;
  logic [NCH-1:0] stopVec, eorVec, rasVec, startVec, endVec;
  logic irq;

  int nChecks = 0;
  int nFails  = 0;

  always #(PERIOD/2) clk = ~clk;

  dmairq_top #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .reqIn(reqIn), .setStart(setStart),
    .setEnd(setEnd), .setStop(setStop), .setRas(setRas), .setEor(setEor),
    .stopVec(stopVec), .eorVec(eorVec), .rasVec(rasVec),
    .startVec(startVec), .endVec(endVec), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic writeWord(input int ch, input logic [1:0] low, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = AW'(ch * 4) | AW'(low); wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  function automatic logic [31:0] vecsAt(input int ch);
    return {27'd0, stopVec[ch], eorVec[ch], rasVec[ch], startVec[ch], endVec[ch]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0;
    reqIn = '0; setStart = '0; setEnd = '0; setStop = '0; setRas = '0; setEor = '0;
    tick(); tick();
    // R1: reset state
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 vectors", 32'({stopVec, eorVec, rasVec, startVec, endVec} != '0), 32'd0);
    check("R1 read", rdData, 32'd0);
    rstN = 1'b1;
    tick();
    check("R1 irq after release", 32'(irq), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      automatic int ch = int'(TABLE[i].chan);
      writeWord(ch, 2'b00, TABLE[i].ctrl | CLR_ALL);
      setStart[ch] = TABLE[i].sets[0];
      setEnd[ch]   = TABLE[i].sets[1];
      setStop[ch]  = TABLE[i].sets[2];
      setRas[ch]   = TABLE[i].sets[3];
      setEor[ch]   = TABLE[i].sets[4];
      reqIn[ch]    = TABLE[i].req;
      tick();
      setStart = '0; setEnd = '0; setStop = '0; setRas = '0; setEor = '0;
      rdAddr = AW'(ch * 4);
      #1;
      check("R7 R10 read word", rdData, TABLE[i].expRead);
      check("R2 R3 R4 R5 channel vectors", vecsAt(ch), 32'(TABLE[i].expVec));
      check("R2 R3 R4 R5 other channels quiet",
            32'(({stopVec, eorVec, rasVec, startVec, endVec} &
                 ~{5{NCH'(1) << ch}}) != '0), 32'd0);
      check("R6 irq lags one cycle", 32'(irq), 32'd0);
      tick();
      check("R6 irq follows vectors", 32'(irq), 32'(TABLE[i].expVec != '0));
      writeWord(ch, 2'b00, TABLE[i].ctrl | CLR_ALL);
      reqIn = '0;
      #1;
      check("R8 cleared read", rdData, TABLE[i].ctrl);
      check("R8 cleared vectors", vecsAt(ch), 32'd0);
      tick();
      check("R6 irq drops", 32'(irq), 32'd0);
    end

    // R9: event pulse and clear write on the same bit, same cycle
    rdAddr = AW'(6 * 4);
    wrEn = 1'b1; wrAddr = AW'(6 * 4); wrData = 32'h0000_0008;
    setStop[6] = 1'b1;
    tick();
    wrEn = 1'b0; setStop = '0;
    check("R9 set beats clear", rdData, 32'h0000_0008);

    // R8: zero leaves status alone, one clears only that bit
    setStart[6] = 1'b1;
    tick();
    setStart = '0;
    check("R8 setup", rdData, 32'h0000_000A);
    writeWord(6, 2'b00, 32'h0000_0000);
    check("R8 zero write keeps status", rdData, 32'h0000_000A);
    writeWord(6, 2'b00, 32'h0000_0002);
    check("R8 one clears only start", rdData, 32'h0000_0008);

    // R11: low address bits ignored, neighbour untouched
    writeWord(6, 2'b11, 32'h0000_0400);
    check("R11 offset bits ignored", rdData, 32'h0000_0408);
    rdAddr = AW'(7 * 4);
    #1;
    check("R11 neighbour unchanged", rdData, 32'h0000_0000);

    // R7: request pending merged live without a clock edge
    rdAddr = AW'(6 * 4);
    reqIn[6] = 1'b1;
    #1;
    check("R7 live request bit", rdData, 32'h0000_0508);
    reqIn = '0;
    #1;
    check("R7 request bit not stored", rdData, 32'h0000_0408);

    finishRun();
  end

endmodule